// File: doc/BRIEF.md
# Per-Core Idle State Sequencer

This block takes one processor core from its executing state into one of several low-power idle states and brings it back. Each hardware thread sharing the core signals that it wants to idle, for example after a halt or monitor-wait, and gives a depth hint. The core goes only as deep as the shallower of the thread requests allows, and it stays active until every thread has asked to idle with a usable hint.

Each depth has its own ordered entry sequence. The two shallow halts keep clocks and voltage on and go on accepting coherence snoops. The deeper of the two halts also asks for the lowest operating point. The clock-stop state first runs a cache flush handshake and then gates the core clocks. The power-off state first runs a state-save handshake and only then gates clocks and drops the core voltage. A wake event reverses the sequence. From power-off, voltage returns first, a fixed settle time passes, clocks restart and a restore handshake completes before the core reports active. A wake that arrives during a flush or save lets that handshake finish and then unwinds to active without stopping clocks. The flush, save and restore engines sit outside the block and are reached through request/done pairs.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core reports state 0 (active), busy low, clock enable and voltage enable high, snoop acceptance high, core_run high, and no flush, save, restore or low-frequency request.
- R2: Hint codes are 1 = light halt, 7 = halt with lowest operating point, 3 = clock stop, 6 = power off. Every other code, code 2 included, is invalid. A thread that gives an invalid hint counts as not idle.
- R3: The core leaves the active state only when every thread has its idle line high with a valid hint. The depth it enters is the shallowest one requested, with light halt < low-frequency halt < clock stop < power off.
- R4: The reported state uses the codes 0 active, 1 light halt, 2 low-frequency halt, 3 clock stop, 4 power off. In codes 1 and 2 the clock and voltage enables stay high, snoop acceptance is high and core_run is low. Code 2 alone raises low_freq_req.
- R5: Entry to clock stop holds flush_req until flush_done and then drops the clock enable. Snoop acceptance is low during that entry and while clocks are stopped.
- R6: Entry to power off holds save_req until save_done. Only after that do the clock and voltage enables drop. Voltage is never off while clocks run.
- R7: A wake in power off raises the voltage enable while clocks stay off for exactly SETTLE_CYC cycles. Clocks then restart with restore_req held until restore_done, and then the core reports active.
- R8: A wake in clock stop restarts clocks in the next cycle, and the core reports active and not busy one cycle after that.
- R9: A wake during a flush or save entry lets the handshake complete and then returns to active with clock and voltage enables never dropped.
- R10: busy is high during every entry and exit step and low in the active and resident idle states.
- R11: A wake in either halt state returns the core to active and not busy in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_idle | input | NTHR | Per-thread idle request level |
| thr_hint | input | NTHR*3 | Per-thread depth hint, thread 0 in the low bits |
| wake | input | 1 | Wake event (interrupt) |
| flush_done | input | 1 | Cache flush engine finished |
| save_done | input | 1 | State save engine finished |
| restore_done | input | 1 | State restore engine finished |
| flush_req | output | 1 | Request to cache flush engine |
| save_req | output | 1 | Request to state save engine |
| restore_req | output | 1 | Request to state restore engine |
| clk_en | output | 1 | Core clock enable |
| vdd_en | output | 1 | Core voltage enable |
| low_freq_req | output | 1 | Ask for lowest operating point |
| snoop_ok | output | 1 | Coherence snoops accepted |
| core_run | output | 1 | Core may execute |
| cstate | output | 3 | Current state code |
| busy | output | 1 | Transition in progress |

## Verification
The bench builds the block with two threads and SETTLE_CYC set to 4. With that setting the whole power-up window can be counted cycle by cycle and compared with the parameter. Random hint pairs over the full 3-bit code space hit every pairing of valid and invalid depths. Handshake stubs answer after random delays, so wakes can be placed inside flush and save windows to reach the abort path.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef enum logic [2:0] {
    CS_C0  = 3'd0,
    CS_C1  = 3'd1,
    CS_C1E = 3'd2,
    CS_C3  = 3'd3,
    CS_C6  = 3'd4
  } cst_e;

  // Hint code to depth; CS_C0 marks an invalid hint.
  function automatic cst_e hint_to_depth(input logic [2:0] hint);
    case (hint)
      3'd1:    return CS_C1;
      3'd7:    return CS_C1E;
      3'd3:    return CS_C3;
      3'd6:    return CS_C6;
      default: return CS_C0;
    endcase
  endfunction

  function automatic cst_e shallower(input cst_e a, input cst_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/idle_req_merge.sv
module idle_req_merge
  import idle_seq_pkg::*;
#(
  parameter int NTHR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   thr_idle,
  input  logic [NTHR*3-1:0] thr_hint,
  output logic              all_idle,
  output cst_e              depth
);
  cst_e            thr_depth [NTHR];
  logic [NTHR-1:0] thr_ok;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign thr_depth[t] = hint_to_depth(thr_hint[t*3 +: 3]);
    assign thr_ok[t]    = thr_idle[t] && (thr_depth[t] != CS_C0);
  end

  always_comb begin
    depth = CS_C6;
    for (int t = 0; t < NTHR; t++) depth = shallower(depth, thr_depth[t]);
  end

  assign all_idle = &thr_ok;

  assert_merge_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    all_idle |-> (depth != CS_C0));
endmodule

// File: rtl/idle_settle_timer.sv
module idle_settle_timer #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !go) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = go && (cnt_q == LAST);

  assert_settle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (cnt_q == '0));
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic all_idle,
  input  cst_e depth,
  input  logic wake,
  input  logic flush_done,
  input  logic save_done,
  input  logic restore_done,
  input  logic settle_done,
  output logic settle_go,
  output logic flush_req,
  output logic save_req,
  output logic restore_req,
  output logic clk_en,
  output logic vdd_en,
  output logic low_freq_req,
  output logic snoop_ok,
  output logic core_run,
  output cst_e cstate,
  output logic busy
);
  typedef enum logic [3:0] {
    S_RUN, S_HALT, S_HALTE, S_FLUSH, S_CSTOP, S_CEXIT,
    S_SAVE, S_POFF, S_PWRUP, S_RESTORE
  } st_e;

  st_e  st_q, st_d;
  logic abort_q;
  logic entry_abort;

  assign entry_abort = abort_q || wake;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_RUN: if (all_idle && !wake) begin
        case (depth)
          CS_C1:   st_d = S_HALT;
          CS_C1E:  st_d = S_HALTE;
          CS_C3:   st_d = S_FLUSH;
          CS_C6:   st_d = S_SAVE;
          default: st_d = S_RUN;
        endcase
      end
      S_HALT, S_HALTE: if (wake) st_d = S_RUN;
      S_FLUSH:   if (flush_done) st_d = entry_abort ? S_RUN : S_CSTOP;
      S_CSTOP:   if (wake) st_d = S_CEXIT;
      S_CEXIT:   st_d = S_RUN;
      S_SAVE:    if (save_done) st_d = entry_abort ? S_RUN : S_POFF;
      S_POFF:    if (wake) st_d = S_PWRUP;
      S_PWRUP:   if (settle_done) st_d = S_RESTORE;
      S_RESTORE: if (restore_done) st_d = S_RUN;
      default:   st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_RUN;
      abort_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_FLUSH || st_q == S_SAVE) abort_q <= entry_abort;
      else abort_q <= 1'b0;
    end
  end

  always_comb begin
    case (st_q)
      S_HALT:                     cstate = CS_C1;
      S_HALTE:                    cstate = CS_C1E;
      S_CSTOP, S_CEXIT:           cstate = CS_C3;
      S_POFF, S_PWRUP, S_RESTORE: cstate = CS_C6;
      default:                    cstate = CS_C0;
    endcase
  end

  assign clk_en       = !(st_q inside {S_CSTOP, S_POFF, S_PWRUP});
  assign vdd_en       = (st_q != S_POFF);
  assign snoop_ok     = st_q inside {S_RUN, S_HALT, S_HALTE};
  assign core_run     = (st_q == S_RUN);
  assign low_freq_req = (st_q == S_HALTE);
  assign flush_req    = (st_q == S_FLUSH);
  assign save_req     = (st_q == S_SAVE);
  assign restore_req  = (st_q == S_RESTORE);
  assign settle_go    = (st_q == S_PWRUP);
  assign busy         = st_q inside {S_FLUSH, S_CEXIT, S_SAVE, S_PWRUP, S_RESTORE};

  assert_vdd_needs_clk_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_en |-> !clk_en);
  assert_save_before_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> $past(save_done));
  assert_no_snoop_clk_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !snoop_ok);
  assert_flush_before_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_en) && vdd_en) |-> $past(flush_done));
  assert_restore_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_req) |-> (vdd_en && clk_en && $past(vdd_en)));
  assert_handshake_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req || save_req || restore_req) |-> busy);
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import idle_seq_pkg::*;
#(
  parameter int NTHR       = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   thr_idle,
  input  logic [NTHR*3-1:0] thr_hint,
  input  logic              wake,
  input  logic              flush_done,
  input  logic              save_done,
  input  logic              restore_done,
  output logic              flush_req,
  output logic              save_req,
  output logic              restore_req,
  output logic              clk_en,
  output logic              vdd_en,
  output logic              low_freq_req,
  output logic              snoop_ok,
  output logic              core_run,
  output logic [2:0]        cstate,
  output logic              busy
);
  logic all_idle, settle_go, settle_done;
  cst_e depth, cst;

  idle_req_merge #(.NTHR(NTHR)) merge_i (
    .clk(clk), .rst_n(rst_n), .thr_idle(thr_idle), .thr_hint(thr_hint),
    .all_idle(all_idle), .depth(depth)
  );

  idle_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk(clk), .rst_n(rst_n), .go(settle_go), .done(settle_done)
  );

  idle_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .all_idle(all_idle), .depth(depth), .wake(wake),
    .flush_done(flush_done), .save_done(save_done), .restore_done(restore_done),
    .settle_done(settle_done), .settle_go(settle_go),
    .flush_req(flush_req), .save_req(save_req), .restore_req(restore_req),
    .clk_en(clk_en), .vdd_en(vdd_en), .low_freq_req(low_freq_req),
    .snoop_ok(snoop_ok), .core_run(core_run), .cstate(cst), .busy(busy)
  );

  assign cstate = cst;
endmodule

// File: tb/core_idle_seq_tb_top.sv
module core_idle_seq_tb_top;
  localparam int SET = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] thr_idle = '0;
  logic [5:0] thr_hint = '0;
  logic       wake = 1'b0;
  logic       flush_done = 1'b0, save_done = 1'b0, restore_done = 1'b0;
  logic       flush_req, save_req, restore_req, clk_en, vdd_en;
  logic       low_freq_req, snoop_ok, core_run, busy;
  logic [2:0] cstate;

  int n_chk = 0, n_fail = 0;
  int fcnt = 0, scnt = 0, rcnt = 0;

  always #5 clk = ~clk;

  core_idle_seq #(.NTHR(2), .SETTLE_CYC(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_idle(thr_idle), .thr_hint(thr_hint),
    .wake(wake), .flush_done(flush_done), .save_done(save_done),
    .restore_done(restore_done), .flush_req(flush_req), .save_req(save_req),
    .restore_req(restore_req), .clk_en(clk_en), .vdd_en(vdd_en),
    .low_freq_req(low_freq_req), .snoop_ok(snoop_ok), .core_run(core_run),
    .cstate(cstate), .busy(busy)
  );

  // Handshake stubs answer after a random delay.
  always @(negedge clk) begin
    if (flush_done) flush_done = 1'b0;
    else if (fcnt > 0) begin fcnt--; if (fcnt == 0) flush_done = 1'b1; end
    else if (flush_req) fcnt = $urandom_range(4, 1);
    if (save_done) save_done = 1'b0;
    else if (scnt > 0) begin scnt--; if (scnt == 0) save_done = 1'b1; end
    else if (save_req) scnt = $urandom_range(4, 1);
    if (restore_done) restore_done = 1'b0;
    else if (rcnt > 0) begin rcnt--; if (rcnt == 0) restore_done = 1'b1; end
    else if (restore_req) rcnt = $urandom_range(4, 1);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int depth_of(input logic [2:0] h);
    if (h == 3'd1) return 1;
    if (h == 3'd7) return 2;
    if (h == 3'd3) return 3;
    if (h == 3'd6) return 4;
    return 0;
  endfunction

  function automatic int expect_state(input logic [2:0] h0, input logic [2:0] h1);
    int a = depth_of(h0);
    int b = depth_of(h1);
    if (a == 0 || b == 0) return 0;
    return (a < b) ? a : b;
  endfunction

  // Request idle on both threads; returns the settled state reached.
  task automatic enter(input logic [2:0] h0, input logic [2:0] h1, output int st);
    @(negedge clk);
    thr_hint = {h1, h0};
    thr_idle = 2'b11;
    st = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busy && cstate != 3'd0) begin st = cstate; break; end
    end
  endtask

  // Wake; counts cycles to active and powered-but-clockless cycles.
  task automatic wake_up(output int lat, output int pw);
    wake = 1'b1;
    thr_idle = 2'b00;
    lat = 0; pw = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      wake = 1'b0;
      lat++;
      if (vdd_en && !clk_en) pw++;
      if (cstate == 3'd0 && !busy) break;
    end
  endtask

  initial begin
    int st, lat, pw, exp_st;
    bit drop;
    void'($urandom(32'h1d1e));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cstate == 0 && !busy, "R1 state/busy", cstate, 0);
    chk(clk_en && vdd_en && snoop_ok && core_run, "R1 enables", {clk_en, vdd_en, snoop_ok, core_run}, 15);
    chk(!flush_req && !save_req && !restore_req && !low_freq_req, "R1 requests", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cstate == 0 && core_run, "R1 after release", cstate, 0);

    // R4/R11 light halt
    enter(3'd1, 3'd1, st);
    chk(st == 1, "R4 light halt state", st, 1);
    chk(clk_en && vdd_en && snoop_ok && !core_run && !low_freq_req, "R4 light halt outputs",
        {clk_en, vdd_en, snoop_ok, core_run, low_freq_req}, 28);
    @(negedge clk);
    wake_up(lat, pw);
    chk(lat == 1, "R11 halt wake latency", lat, 1);

    // R4 low-frequency halt
    enter(3'd7, 3'd7, st);
    chk(st == 2 && low_freq_req && snoop_ok, "R4 low-freq halt", st, 2);
    @(negedge clk);
    wake_up(lat, pw);
    chk(lat == 1, "R11 low-freq wake latency", lat, 1);

    // R3 shallower wins
    enter(3'd1, 3'd6, st);
    chk(st == 1, "R3 min of light/poweroff", st, 1);
    @(negedge clk); wake_up(lat, pw);

    // R5/R8 clock stop
    enter(3'd3, 3'd6, st);
    chk(st == 3, "R5 clock stop reached", st, 3);
    chk(!clk_en && vdd_en && !snoop_ok && !flush_req, "R5 clocks off, no snoop",
        {clk_en, snoop_ok}, 0);
    @(negedge clk);
    wake_up(lat, pw);
    chk(lat == 2, "R8 clock stop wake latency", lat, 2);

    // R6/R7 power off
    enter(3'd6, 3'd6, st);
    chk(st == 4 && !vdd_en && !clk_en, "R6 power off", {vdd_en, clk_en}, 0);
    @(negedge clk);
    wake_up(lat, pw);
    chk(pw == SET, "R7 settle cycles", pw, SET);
    chk(cstate == 0 && clk_en && vdd_en, "R7 back active", cstate, 0);

    // R2 invalid hints, R3 single thread
    @(negedge clk);
    thr_hint = {3'd2, 3'd2}; thr_idle = 2'b11;
    repeat (8) @(negedge clk);
    chk(cstate == 0 && core_run && !busy, "R2 code 2 ignored", cstate, 0);
    thr_hint = {3'd6, 3'd4};
    repeat (8) @(negedge clk);
    chk(cstate == 0 && core_run && !busy, "R2 one invalid hint", cstate, 0);
    thr_hint = {3'd6, 3'd6}; thr_idle = 2'b01;
    repeat (8) @(negedge clk);
    chk(cstate == 0 && core_run && !busy, "R3 one thread only", cstate, 0);
    thr_idle = 2'b00;
    @(negedge clk);

    // R9 abort during flush, then during save
    for (int k = 0; k < 2; k++) begin
      thr_hint = (k == 0) ? {3'd3, 3'd3} : {3'd6, 3'd6};
      thr_idle = 2'b11;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (flush_req || save_req) break;
      end
      chk(busy, "R10 busy in entry", busy, 1);
      wake = 1'b1; thr_idle = 2'b00;
      drop = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        wake = 1'b0;
        if (!clk_en || !vdd_en) drop = 1;
        if (!busy) break;
      end
      chk(!drop, "R9 enables held on abort", drop, 0);
      chk(cstate == 0 && core_run && !busy, "R9 back active", cstate, 0);
    end

    // Random hint pairs
    for (int n = 0; n < 60; n++) begin
      logic [2:0] h0 = 3'($urandom_range(7, 0));
      logic [2:0] h1 = 3'($urandom_range(7, 0));
      exp_st = expect_state(h0, h1);
      enter(h0, h1, st);
      chk(st == exp_st, "R3 random depth", st, exp_st);
      if (st == 0) begin
        chk(!busy && core_run, "R2 random stays active", cstate, 0);
        thr_idle = 2'b00;
        @(negedge clk);
      end else begin
        chk(snoop_ok == (st <= 2), "R4 random snoop", snoop_ok, st <= 2);
        @(negedge clk);
        wake_up(lat, pw);
        chk(lat == ((st <= 2) ? 1 : (st == 3) ? 2 : lat), "R8 random latency", lat, lat);
        if (st == 4) chk(pw == SET, "R7 random settle", pw, SET);
        chk(cstate == 0 && !busy, "R10 random return", cstate, 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule